// File: doc/BRIEF.md
# Programmable Page-Mapping Register File

This block widens a processor address. A 16-bit processor address has its four top bits replaced by a 12-bit page number. The page number comes from one of sixteen software-programmable 12-bit map registers. The four top address bits, called the map address here, select which map register supplies the page. The lower address bits bypass the block. Splitting the result into chip selects is left to downstream logic.

Software programs the registers through a small bus port. That port has a four-bit register select, a 12-bit data bus in each direction, an active-low chip select, an active-low strobe and a read/write line. A register can be rewritten at any moment, so the mapping can change while the system runs.

Three controls shape the page output:
- **Pass-through mode.** The map address goes to the top of the page and the low bits are zero, so the mapper becomes transparent.
- **Output disable.** Marks the page bus as not driven. High impedance is modelled as a separate drive-enable output.
- **Hold control.** Freezes the registered page output while it is low.

Bus accesses decode to one of three kinds: IDLE, READ or WRITE. The output stage has two modes:
- TRACK (hold high): the page register loads the new mapping on every clock.
- HOLD (hold low): the page register keeps its value.

Hold is sampled on each clock, so the transitions are:
- TRACK to HOLD and HOLD to HOLD when hold is low.
- HOLD to TRACK and TRACK to TRACK when hold is high.

Top module: `page_mapper`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) loads map register n with n in bits 11:8 and zeros in bits 7:0, and clears the page output to 0.
- R2: At a rising edge with `cs_n_i`=0, `rw_i`=0 and `stb_n_i`=0 (a WRITE), register `reg_sel_i` takes the value of `data_i`.
- R3: While `cs_n_i`=0 and `rw_i`=1 (a READ), `data_oe_o` is 1 and `data_o` equals the register chosen by `reg_sel_i`, combinationally. At all other times `data_oe_o` is 0.
- R4: With `pass_mode_i`=1 and `hold_i`=1 at a rising edge, after that edge `page_o[11:8]` equals the `map_addr_i` sampled there and `page_o[7:0]` is 0.
- R5: With `pass_mode_i`=0 and `hold_i`=1 at a rising edge, after that edge `page_o` equals the register chosen by `map_addr_i`, as it stood before that edge.
- R6: `page_oe_o` is the inverse of `out_dis_i` (1 = page driven, 0 = high impedance), combinationally.
- R7: With `hold_i`=0 at a rising edge, `page_o` keeps its value across that edge, whatever the other inputs do.
- R8: A WRITE to the register currently shown on the page appears on `page_o` one edge after the write edge, unless hold is low.
- R9: A strobe with `rw_i`=1 or with `cs_n_i`=1 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| reg_sel_i | input | 4 | Register select for programming accesses |
| map_addr_i | input | 4 | Top processor address bits that select the mapping |
| data_i | input | 12 | Write data for the map registers |
| cs_n_i | input | 1 | Chip select, active low |
| stb_n_i | input | 1 | Write strobe, active low |
| rw_i | input | 1 | 1 = read, 0 = write |
| pass_mode_i | input | 1 | 1 = pass-through page, 0 = register page |
| out_dis_i | input | 1 | 1 = page bus high impedance |
| hold_i | input | 1 | 1 = page tracks mapping, 0 = page frozen |
| page_o | output | 12 | Mapped page value |
| page_oe_o | output | 1 | Page bus drive enable |
| data_o | output | 12 | Read data |
| data_oe_o | output | 1 | Read data drive enable |

## Verification
A corrupted map register shows on `data_o` in the same cycle it is read back. It also shows on `page_o` one edge after its map address is presented with hold high. The bench therefore compares every read and every page value against a model on each cycle.

A wrong output-stage mode shows as a page that moves while hold is low, or that stays still while hold is high, one edge after the mismatch. Random programming traffic is mixed with directed cases around reset, ignored strobes and writes to the register currently on the page, so that a lost or misdirected write surfaces within one or two cycles.

// File: rtl/page_map_pkg.sv
package page_map_pkg;

    // Decoded kind of a programming-port access
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    // Mode of the page output register
    typedef enum logic {
        LAT_TRACK = 1'b0,
        LAT_HOLD  = 1'b1
    } lat_mode_e;

    function automatic acc_kind_e decode_access(input logic cs_n,
                                                input logic rw,
                                                input logic stb_n);
        acc_kind_e k;
        k = ACC_IDLE;
        if (!cs_n) begin
            if (rw)          k = ACC_READ;
            else if (!stb_n) k = ACC_WRITE;
        end
        return k;
    endfunction

endpackage

// File: rtl/map_regfile.sv
module map_regfile #(
    parameter int SEL_W  = 4,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_a_sel,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [SEL_W-1:0]  rd_b_sel,
    output logic [DATA_W-1:0] rd_b_data
);
    localparam int NUM_REGS = 1 << SEL_W;
    localparam int SHIFT    = DATA_W - SEL_W;

    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= DATA_W'(i) << SHIFT;
            end
        end else if (wr_en) begin
            regs_q[wr_sel] <= wr_data;
        end
    end

    assign rd_a_data = regs_q[rd_a_sel];
    assign rd_b_data = regs_q[rd_b_sel];

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> regs_q[$past(wr_sel)] == $past(wr_data));

    // R9
    no_write_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs_q));

endmodule

// File: rtl/map_select.sv
module map_select #(
    parameter int SEL_W  = 4,
    parameter int DATA_W = 12
) (
    input  logic              pass_mode,
    input  logic [SEL_W-1:0]  map_addr,
    input  logic [DATA_W-1:0] reg_data,
    output logic [DATA_W-1:0] map_value
);
    localparam int LOW_W = DATA_W - SEL_W;

    logic [DATA_W-1:0] pass_value;

    generate
        if (LOW_W > 0) begin : g_pad
            assign pass_value = {map_addr, {LOW_W{1'b0}}};
        end else begin : g_nopad
            assign pass_value = map_addr[SEL_W-1 -: DATA_W];
        end
    endgenerate

    always_comb begin
        map_value = pass_mode ? pass_value : reg_data;
    end

endmodule

// File: rtl/map_out_latch.sv
module map_out_latch
    import page_map_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_i,
    input  logic [DATA_W-1:0] map_value,
    output logic [DATA_W-1:0] page_q
);
    lat_mode_e mode;

    always_comb begin
        mode = hold_i ? LAT_TRACK : LAT_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
        end else begin
            unique case (mode)
                LAT_TRACK: page_q <= map_value;
                LAT_HOLD:  page_q <= page_q;
                default:   page_q <= page_q;
            endcase
        end
    end

    // R7
    frozen_page_chk: assert property (@(posedge clk) disable iff (rst)
        !hold_i |=> page_q == $past(page_q));

endmodule

// File: rtl/page_mapper.sv
module page_mapper
    import page_map_pkg::*;
#(
    parameter int SEL_W  = 4,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  reg_sel_i,
    input  logic [SEL_W-1:0]  map_addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              cs_n_i,
    input  logic              stb_n_i,
    input  logic              rw_i,
    input  logic              pass_mode_i,
    input  logic              out_dis_i,
    input  logic              hold_i,
    output logic [DATA_W-1:0] page_o,
    output logic              page_oe_o,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o
);
    localparam int LOW_W = DATA_W - SEL_W;

    acc_kind_e         acc;
    logic              wr_en;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] map_reg_data;
    logic [DATA_W-1:0] map_value;

    always_comb begin
        acc = decode_access(cs_n_i, rw_i, stb_n_i);
    end

    always_comb begin
        wr_en     = 1'b0;
        data_oe_o = 1'b0;
        unique case (acc)
            ACC_IDLE:  ;
            ACC_READ:  data_oe_o = 1'b1;
            ACC_WRITE: wr_en     = 1'b1;
            default:   ;
        endcase
    end

    assign data_o    = rd_data;
    assign page_oe_o = ~out_dis_i;

    map_regfile #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (reg_sel_i),
        .wr_data   (data_i),
        .rd_a_sel  (reg_sel_i),
        .rd_a_data (rd_data),
        .rd_b_sel  (map_addr_i),
        .rd_b_data (map_reg_data)
    );

    map_select #(.SEL_W(SEL_W), .DATA_W(DATA_W)) u_sel (
        .pass_mode (pass_mode_i),
        .map_addr  (map_addr_i),
        .reg_data  (map_reg_data),
        .map_value (map_value)
    );

    map_out_latch #(.DATA_W(DATA_W)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .hold_i    (hold_i),
        .map_value (map_value),
        .page_q    (page_o)
    );

    // R4
    pass_page_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_i && pass_mode_i) |=>
            (page_o[DATA_W-1 -: SEL_W] == $past(map_addr_i)) &&
            (page_o[LOW_W-1:0] == '0));

    // R5
    reg_page_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_i && !pass_mode_i) |=> page_o == $past(map_reg_data));

    // R3
    read_only_when_selected_chk: assert property (@(posedge clk) disable iff (rst)
        data_oe_o |-> (!cs_n_i && rw_i && !wr_en));

endmodule

// File: tb/test_page_mapper.sv
`timescale 1ns/1ps
module test_page_mapper;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  sel = '0;
    logic [3:0]  ma = '0;
    logic [11:0] wd = '0;
    logic        cs_n = 1'b1;
    logic        stb_n = 1'b1;
    logic        rw = 1'b1;
    logic        pass = 1'b0;
    logic        dis = 1'b0;
    logic        hold = 1'b1;
    logic [11:0] page_o, data_o;
    logic        page_oe_o, data_oe_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [11:0] m [16];
    logic [11:0] out_exp;
    logic        last_pass, last_hold;

    always #4 clk = ~clk;

    page_mapper i_page_mapper (
        .clk(clk), .rst(rst), .reg_sel_i(sel), .map_addr_i(ma), .data_i(wd),
        .cs_n_i(cs_n), .stb_n_i(stb_n), .rw_i(rw), .pass_mode_i(pass),
        .out_dis_i(dis), .hold_i(hold), .page_o(page_o), .page_oe_o(page_oe_o),
        .data_o(data_o), .data_oe_o(data_oe_o)
    );

    function automatic logic [11:0] reset_val(input int n);
        return 12'(n) << 8;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [11:0] act,
                       input logic [11:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%03h expected=%03h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        string t;
        t = !last_hold ? "R7" : (last_pass ? "R4" : "R5");
        chk(page_o === out_exp, t, page_o, out_exp);
        chk(page_oe_o === !dis, "R6", 12'(page_oe_o), 12'(!dis));
        chk(data_oe_o === (!cs_n && rw), "R3", 12'(data_oe_o), 12'(!cs_n && rw));
        if (!cs_n && rw) chk(data_o === m[sel], "R3", data_o, m[sel]);
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < 16; i++) m[i] = reset_val(i);
            out_exp = '0;
            last_hold = 1'b1;
            last_pass = 1'b0;
        end else begin
            if (hold) out_exp = pass ? {ma, 8'h00} : m[ma];
            if (!cs_n && !rw && !stb_n) m[sel] = wd;
            last_pass = pass;
            last_hold = hold;
        end
        @(negedge clk);
        check_all();
    endtask

    task automatic idle();
        cs_n = 1'b1; stb_n = 1'b1; rw = 1'b1;
    endtask

    task automatic do_write(input logic [3:0] s, input logic [11:0] v);
        sel = s; wd = v; cs_n = 1'b0; rw = 1'b0; stb_n = 1'b0;
        tick();
        idle();
    endtask

    task automatic read_expect(input logic [3:0] s, input logic [11:0] v,
                               input string tag);
        sel = s; cs_n = 1'b0; rw = 1'b1; stb_n = 1'b1;
        #1;
        chk(data_o === v && data_oe_o === 1'b1, tag, data_o, v);
        idle();
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%03h expected=%03h", 12'h0, 12'h1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [11:0] held;
        void'($urandom(32'd1234));
        for (int i = 0; i < 3; i++) tick();
        rst = 1'b0;
        @(negedge clk);
        // R1: reset contents and page
        chk(page_o === 12'h000, "R1", page_o, 12'h000);
        for (int i = 0; i < 16; i++) read_expect(4'(i), reset_val(i), "R1");

        // R2: plain write then read back
        do_write(4'd5, 12'hABC);
        read_expect(4'd5, 12'hABC, "R2");

        // R9: strobe with rw high, and strobe with cs high
        sel = 4'd5; wd = 12'h111; cs_n = 1'b0; rw = 1'b1; stb_n = 1'b0; tick();
        sel = 4'd5; wd = 12'h222; cs_n = 1'b1; rw = 1'b0; stb_n = 1'b0; tick();
        idle();
        read_expect(4'd5, 12'hABC, "R9");

        // R4: pass-through page
        pass = 1'b1; ma = 4'hD; tick();
        chk(page_o === 12'hD00, "R4", page_o, 12'hD00);

        // R5 / R8: register page, then write the shown register
        pass = 1'b0; ma = 4'd5; tick();
        chk(page_o === 12'hABC, "R5", page_o, 12'hABC);
        sel = 4'd5; wd = 12'h123; cs_n = 1'b0; rw = 1'b0; stb_n = 1'b0; tick();
        idle();
        chk(page_o === 12'hABC, "R8", page_o, 12'hABC);
        tick();
        chk(page_o === 12'h123, "R8", page_o, 12'h123);

        // R7: freeze, then change mapping and rewrite
        hold = 1'b0; ma = 4'd9; pass = 1'b1; tick();
        do_write(4'd5, 12'h777);
        chk(page_o === 12'h123, "R7", page_o, 12'h123);
        hold = 1'b1; tick();
        chk(page_o === 12'h900, "R7", page_o, 12'h900);

        // R6: output disable
        dis = 1'b1; #1;
        chk(12'(page_oe_o) === 12'h0, "R6", 12'(page_oe_o), 12'h0);
        dis = 1'b0; #1;
        chk(12'(page_oe_o) === 12'h1, "R6", 12'(page_oe_o), 12'h1);

        // Random traffic
        for (int n = 0; n < 1500; n++) begin
            sel   = 4'($urandom);
            ma    = 4'($urandom);
            wd    = 12'($urandom);
            cs_n  = ($urandom % 3) == 0;
            rw    = ($urandom % 2) == 0;
            stb_n = ($urandom % 3) == 0;
            pass  = ($urandom % 4) == 0;
            dis   = ($urandom % 5) == 0;
            hold  = ($urandom % 5) != 0;
            held  = page_o;
            tick();
        end

        idle();
        hold = 1'b1;
        rst = 1'b1; tick(); rst = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 16; i++) read_expect(4'(i), reset_val(i), "R1");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule